// File: doc/BRIEF.md
# Command-Driven Byte Flash Controller

This block is the control side of a byte-wide, command-driven flash memory. A host drives an asynchronous bus with an active-low select, an active-low read strobe, an active-low write strobe, an 18-bit address and an 8-bit data bus. The block samples these pins on its own clock. Each write is a command byte or, after a set-up command, an operand. The block moves between read, identifier, erase set-up, erasing, erase verify, program set-up, programming and program verify states.

Destructive operations need two writes: a set-up write, then an execute write. A running erase or program is not ended by a timer. It ends when the rising edge of the next write strobe arrives, and that write normally carries a verify command. The address is captured when the write strobe falls and the data when it rises. Single-cycle start and stop pulses go to the erase and program engines. A read returns array data, an identifier code or the verify byte, depending on the state. A small behavioural store stands in for the cell array. The data bus is split into an input, an output and an output-enable, so that the chip level can build the three-state buffer.

The host uses it as any such part: it writes command sequences with the high-voltage flag asserted, and it reads back results with select and read strobe low.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the block is in array read mode, all four engine pulses are low, and the store holds FFh in every byte.
- R2: `dq_oe` is high only while both `sel_n` and `rden_n` are low. In array read mode `dq_out` is the stored byte at the low address bits of `addr`.
- R3: Writing 90h enters identifier mode. A read there returns 89h at address 0, BDh at address 1 and 00h elsewhere. The mode lasts until another command is written.
- R4: Writing 20h twice in a row gives one `erase_go` pulse on the rising edge of the second write strobe, and every stored byte becomes FFh.
- R5: During erase set-up, a write of any byte other than 20h cancels the set-up without an erase pulse and is decoded as a new command.
- R6: While erasing, the next write gives one `erase_end` pulse. If that byte is A0h, erase verify mode is entered, and reads return the byte at the address latched on that write's falling edge, whatever the current read address.
- R7: After 40h, the next write latches the address on the falling edge and the data on the rising edge. It gives one `prog_go` pulse, and the addressed byte becomes its old value ANDed with the data.
- R8: While programming, the next write gives one `prog_end` pulse. If that byte is C0h, program verify mode is entered. Reads return the byte last programmed, and the address on the C0h write is ignored.
- R9: While `vhv_ok` is low, a write changes no mode, no stored byte and no pulse output.
- R10: Writing 00h, or any byte that is not a command, returns the block to array read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low device select |
| rden_n | input | 1 | Active-low read (output gate) strobe |
| wrstb_n | input | 1 | Active-low write strobe |
| vhv_ok | input | 1 | High-voltage supply present flag |
| addr | input | 18 | Byte address |
| dq_in | input | 8 | Data bus, host to block |
| dq_out | output | 8 | Data bus, block to host |
| dq_oe | output | 1 | Drive enable for the data bus |
| erase_go | output | 1 | Erase engine start pulse |
| erase_end | output | 1 | Erase engine stop pulse |
| prog_go | output | 1 | Program engine start pulse |
| prog_end | output | 1 | Program engine stop pulse |

## Verification
The assertions take for granted that a write strobe stays low, and then high, for several clock periods. This lets the synchronised edges be seen one at a time. They also take for granted that `addr`, `dq_in` and `vhv_ok` do not move from a strobe edge until that edge has passed the synchroniser. The bench drives every write with six clocks low and six clocks high. It holds the address, the data and the supply flag through the whole write, and changes inputs only on falling clock edges.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

  typedef enum logic [2:0] {
    M_READ      = 3'd0,
    M_IDENT     = 3'd1,
    M_ERS_SU    = 3'd2,
    M_ERASING   = 3'd3,
    M_ERS_VFY   = 3'd4,
    M_PGM_SU    = 3'd5,
    M_PROGRAM   = 3'd6,
    M_PGM_VFY   = 3'd7
  } mode_t;

  localparam logic [7:0] OP_READ  = 8'h00;
  localparam logic [7:0] OP_IDENT = 8'h90;
  localparam logic [7:0] OP_ERASE = 8'h20;
  localparam logic [7:0] OP_EVFY  = 8'hA0;
  localparam logic [7:0] OP_PGM   = 8'h40;
  localparam logic [7:0] OP_PVFY  = 8'hC0;

  localparam logic [7:0] ID_MAKER  = 8'h89;
  localparam logic [7:0] ID_DEVICE = 8'hBD;

  // Mode entered by a command byte; unknown bytes fall back to array read.
  function automatic mode_t decode_op(input logic [7:0] op);
    case (op)
      OP_IDENT: decode_op = M_IDENT;
      OP_ERASE: decode_op = M_ERS_SU;
      OP_EVFY:  decode_op = M_ERS_VFY;
      OP_PGM:   decode_op = M_PGM_SU;
      OP_PVFY:  decode_op = M_PGM_VFY;
      default:  decode_op = M_READ;
    endcase
  endfunction

  // Identifier byte for a given address.
  function automatic logic [7:0] ident_byte(input logic [17:0] a);
    if (a == 18'd0)      ident_byte = ID_MAKER;
    else if (a == 18'd1) ident_byte = ID_DEVICE;
    else                 ident_byte = 8'h00;
  endfunction

  // Programming can only clear bits.
  function automatic logic [7:0] pgm_merge(input logic [7:0] old_b,
                                           input logic [7:0] new_b);
    pgm_merge = old_b & new_b;
  endfunction

endpackage

// File: rtl/fcc_edge_sync.sv
module fcc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic fall_ev,
  output logic rise_ev
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], strobe_n};
      prev  <= chain[STAGES-1];
    end
  end

  assign fall_ev = prev & ~chain[STAGES-1];
  assign rise_ev = ~prev & chain[STAGES-1];
endmodule

// File: rtl/fcc_decoder.sv
module fcc_decoder
  import fcc_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fall_ev,
  input  logic          rise_ev,
  input  logic          vhv_ok,
  input  logic [AW-1:0] addr_lo,
  input  logic [7:0]    data_in,
  output mode_t         mode,
  output logic [AW-1:0] vfy_addr,
  output logic [AW-1:0] wr_addr,
  output logic          pgm_en,
  output logic          erase_all,
  output logic          erase_go,
  output logic          erase_end,
  output logic          prog_go,
  output logic          prog_end
);
  logic  wr_ok;
  mode_t dec_mode;

  assign wr_ok     = rise_ev & vhv_ok;
  assign dec_mode  = decode_op(data_in);
  assign pgm_en    = wr_ok & (mode == M_PGM_SU);
  assign erase_all = wr_ok & (mode == M_ERS_SU) & (data_in == OP_ERASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= M_READ;
      vfy_addr  <= '0;
      wr_addr   <= '0;
      erase_go  <= 1'b0;
      erase_end <= 1'b0;
      prog_go   <= 1'b0;
      prog_end  <= 1'b0;
    end else begin
      erase_go  <= 1'b0;
      erase_end <= 1'b0;
      prog_go   <= 1'b0;
      prog_end  <= 1'b0;
      if (fall_ev) wr_addr <= addr_lo;
      if (wr_ok) begin
        if (mode == M_ERS_SU && data_in == OP_ERASE) begin
          mode     <= M_ERASING;
          erase_go <= 1'b1;
        end else if (mode == M_PGM_SU) begin
          mode     <= M_PROGRAM;
          prog_go  <= 1'b1;
          vfy_addr <= wr_addr;
        end else begin
          if (mode == M_ERASING) erase_end <= 1'b1;
          if (mode == M_PROGRAM) prog_end  <= 1'b1;
          mode <= dec_mode;
          if (data_in == OP_EVFY) vfy_addr <= wr_addr;
        end
      end
    end
  end
endmodule

// File: rtl/fcc_store.sv
module fcc_store
  import fcc_pkg::*;
#(
  parameter int AW = 4,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          erase_all,
  input  logic          pgm_en,
  input  logic [AW-1:0] pgm_addr,
  input  logic [7:0]    pgm_data,
  input  logic [AW-1:0] rd_addr,
  input  logic [AW-1:0] vf_addr,
  output logic [7:0]    rd_data,
  output logic [7:0]    vf_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (erase_all) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (pgm_en) begin
      mem[pgm_addr] <= pgm_merge(mem[pgm_addr], pgm_data);
    end
  end

  assign rd_data = mem[rd_addr];
  assign vf_data = mem[vf_addr];
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcc_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int STORE_AW = 4,
  parameter int SYNC_ST = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              rden_n,
  input  logic              wrstb_n,
  input  logic              vhv_ok,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dq_in,
  output logic [7:0]        dq_out,
  output logic              dq_oe,
  output logic              erase_go,
  output logic              erase_end,
  output logic              prog_go,
  output logic              prog_end
);
  logic                wr_n;
  logic                fall_ev;
  logic                rise_ev;
  mode_t               mode;
  logic [STORE_AW-1:0] vfy_addr;
  logic [STORE_AW-1:0] wr_addr;
  logic                pgm_en;
  logic                erase_all;
  logic [7:0]          rd_data;
  logic [7:0]          vf_data;
  logic [7:0]          sel_byte;

  assign wr_n = sel_n | wrstb_n;

  fcc_edge_sync #(.STAGES(SYNC_ST)) u_sync (
    .clk(clk), .rst_n(rst_n), .strobe_n(wr_n),
    .fall_ev(fall_ev), .rise_ev(rise_ev)
  );

  fcc_decoder #(.AW(STORE_AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .fall_ev(fall_ev), .rise_ev(rise_ev),
    .vhv_ok(vhv_ok), .addr_lo(addr[STORE_AW-1:0]), .data_in(dq_in),
    .mode(mode), .vfy_addr(vfy_addr), .wr_addr(wr_addr),
    .pgm_en(pgm_en), .erase_all(erase_all),
    .erase_go(erase_go), .erase_end(erase_end),
    .prog_go(prog_go), .prog_end(prog_end)
  );

  fcc_store #(.AW(STORE_AW)) u_store (
    .clk(clk), .rst_n(rst_n), .erase_all(erase_all), .pgm_en(pgm_en),
    .pgm_addr(wr_addr), .pgm_data(dq_in),
    .rd_addr(addr[STORE_AW-1:0]), .vf_addr(vfy_addr),
    .rd_data(rd_data), .vf_data(vf_data)
  );

  always_comb begin
    case (mode)
      M_IDENT:              sel_byte = ident_byte(18'(addr));
      M_ERS_VFY, M_PGM_VFY: sel_byte = vf_data;
      default:              sel_byte = rd_data;
    endcase
  end

  assign dq_oe  = ~sel_n & ~rden_n;
  assign dq_out = dq_oe ? sel_byte : 8'h00;
endmodule

// File: rtl/fcc_chk.sv
module fcc_chk
  import fcc_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input mode_t mode,
  input logic  rise_ev,
  input logic  vhv_ok,
  input logic  erase_go,
  input logic  erase_end,
  input logic  prog_go,
  input logic  prog_end
);
  p_one_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({erase_go, erase_end, prog_go, prog_end}));

  p_erase_after_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |-> (mode == M_ERASING) && ($past(mode) == M_ERS_SU));

  p_erase_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    erase_end |-> $past(mode) == M_ERASING);

  p_prog_after_setup_r7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_go |-> (mode == M_PROGRAM) && ($past(mode) == M_PGM_SU));

  p_prog_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    prog_end |-> $past(mode) == M_PROGRAM);

  p_no_hv_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_ev && !vhv_ok) |=> $stable(mode) && !erase_go && !prog_go);
endmodule

bind flash_cmd_ctrl fcc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .rise_ev(rise_ev),
  .vhv_ok(vhv_ok), .erase_go(erase_go), .erase_end(erase_end),
  .prog_go(prog_go), .prog_end(prog_end)
);

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n = 1'b1;
  logic        rden_n = 1'b1;
  logic        wrstb_n = 1'b1;
  logic        vhv_ok = 1'b1;
  logic [17:0] addr = '0;
  logic [7:0]  dq_in = '0;
  logic [7:0]  dq_out;
  logic        dq_oe;
  logic        erase_go, erase_end, prog_go, prog_end;

  int total = 0;
  int bad = 0;
  int n_eg = 0, n_ee = 0, n_pg = 0, n_pe = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  flash_cmd_ctrl i_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rden_n(rden_n),
    .wrstb_n(wrstb_n), .vhv_ok(vhv_ok), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .erase_go(erase_go),
    .erase_end(erase_end), .prog_go(prog_go), .prog_end(prog_end)
  );

  always @(posedge clk) begin
    if (erase_go)  n_eg++;
    if (erase_end) n_ee++;
    if (prog_go)   n_pg++;
    if (prog_end)  n_pe++;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr_cnt();
    n_eg = 0; n_ee = 0; n_pg = 0; n_pe = 0;
  endtask

  task automatic bus_write(input logic [17:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; dq_in = d; sel_n = 1'b0; rden_n = 1'b1; wrstb_n = 1'b0;
    repeat (6) @(negedge clk);
    wrstb_n = 1'b1;
    repeat (6) @(negedge clk);
    sel_n = 1'b1;
  endtask

  task automatic bus_read(input logic [17:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; sel_n = 1'b0; rden_n = 1'b0;
    @(negedge clk);
    d = dq_out;
    rden_n = 1'b1; sel_n = 1'b1;
  endtask

  // {command, read address, expected read}
  localparam logic [33:0] VEC [7] = '{
    {8'h90, 18'd0, 8'h89},   // R3
    {8'h90, 18'd1, 8'hBD},   // R3
    {8'h90, 18'd5, 8'h00},   // R3
    {8'h00, 18'd0, 8'hFF},   // R10
    {8'h90, 18'd1, 8'hBD},   // R3
    {8'h55, 18'd1, 8'hFF},   // R10 unknown byte
    {8'hFF, 18'd0, 8'hFF}    // R10
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    check("R1 oe", dq_oe, 0);
    check("R1 pulses", {erase_go, erase_end, prog_go, prog_end}, 0);
    bus_read(18'd9, r);
    check("R1 store FF", r, 8'hFF);

    // R2 output gating
    @(negedge clk); sel_n = 1'b0; rden_n = 1'b1;
    @(negedge clk); check("R2 rden high", dq_oe, 0);
    sel_n = 1'b1; rden_n = 1'b0;
    @(negedge clk); check("R2 sel high", dq_oe, 0);
    sel_n = 1'b0;
    @(negedge clk); check("R2 both low", dq_oe, 1);
    rden_n = 1'b1; sel_n = 1'b1;

    // Table walk
    for (int i = 0; i < 7; i++) begin
      bus_write(18'd0, VEC[i][33:26]);
      bus_read(VEC[i][25:8], r);
      check("R3/R10 table", r, VEC[i][7:0]);
    end

    // R7 / R8 program then verify
    bus_write(18'd0, 8'h00);
    clr_cnt();
    bus_write(18'd0, 8'h40);
    bus_write(18'd3, 8'h5A);
    check("R7 prog_go", n_pg, 1);
    bus_write(18'd7, 8'hC0);
    check("R8 prog_end", n_pe, 1);
    bus_read(18'd0, r);
    check("R8 verify ignores addr", r, 8'h5A);
    bus_write(18'd0, 8'h40);
    bus_write(18'd3, 8'h0F);
    bus_write(18'd0, 8'hC0);
    bus_read(18'd12, r);
    check("R7 AND merge", r, 8'h0A);
    bus_write(18'd0, 8'h00);
    bus_read(18'd3, r);
    check("R2 read programmed", r, 8'h0A);

    // R9 no high voltage
    clr_cnt();
    vhv_ok = 1'b0;
    bus_write(18'd0, 8'h90);
    bus_read(18'd0, r);
    check("R9 mode kept", r, 8'hFF);
    bus_write(18'd0, 8'h40);
    bus_write(18'd3, 8'h00);
    vhv_ok = 1'b1;
    check("R9 no prog pulse", n_pg, 0);
    bus_read(18'd3, r);
    check("R9 byte kept", r, 8'h0A);

    // R5 cancelled erase set-up
    clr_cnt();
    bus_write(18'd0, 8'h20);
    bus_write(18'd0, 8'h90);
    check("R5 no erase", n_eg, 0);
    bus_read(18'd0, r);
    check("R5 decoded as ident", r, 8'h89);
    bus_write(18'd0, 8'h00);
    bus_read(18'd3, r);
    check("R5 byte kept", r, 8'h0A);

    // R4 / R6 erase and verify
    clr_cnt();
    bus_write(18'd0, 8'h20);
    bus_write(18'd0, 8'h20);
    check("R4 erase_go", n_eg, 1);
    bus_write(18'd3, 8'hA0);
    check("R6 erase_end", n_ee, 1);
    bus_read(18'd0, r);
    check("R6 verify byte", r, 8'hFF);
    bus_write(18'd0, 8'h00);
    bus_read(18'd3, r);
    check("R4 erased", r, 8'hFF);
    check("R4 single pulse", n_eg, 1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule